// File: doc/BRIEF.md
# Triple-Modulus Frequency Divider

This block divides a fast input clock by 64, 65 or 72. Two mode-select pins choose the ratio. It sits in the feedback path of a frequency synthesizer. The synthesizer loop changes the mode pins from one output period to the next, which lets it reach fine frequency steps while keeping a high comparison rate. Every state element switches on the rising edge of the input clock only, and nothing in the design depends on how fast that clock runs.

The division uses two stages. The front stage counts four input edges per step, or five when it is told to extend. A five-bit secondary counter counts the front stage's steps. A small mode register captures the pins once per output period. From that pair it sets the secondary counter's terminal count (16 or 18 steps). It also sets whether the front stage stretches to five edges during the last secondary step, which adds one edge to the period. The output waveform is a registered differential pair. Within every period it falls and rises at fixed positions.

Top module: `tri_modulus_divider`

## Requirements
- R1: With `sel_std`=1 and `sel_wide`=0 latched, consecutive falling edges of `div_out` are exactly 64 input rising edges apart.
- R2: With `sel_std`=0 and `sel_wide`=0 latched, consecutive falling edges of `div_out` are exactly 65 input rising edges apart.
- R3: With `sel_wide`=1 latched, the period is exactly 72 input rising edges for either value of `sel_std`.
- R4: The front stage counts four input edges per step. The only exception is the 65 mode, where it counts five during the last step of the secondary counter. The secondary counter runs 16 steps per period, or 18 in the 72 mode, and advances only when the front stage completes a step.
- R5: `div_out` falls on the final input count of a period, which is count N for modulus N. It rises on count 32 of the next period, exactly 32 input edges after the fall.
- R6: The mode pins are sampled only on the input edge that closes a period. A period already in progress always completes with its old modulus. Pin changes that revert before that closing edge have no effect.
- R7: `div_out_n` is the exact inverse of `div_out` in every cycle.
- R8: A synchronous active-high `rst` places the divider at count 1 of a period with `div_out`=1 and `div_out_n`=0, and latches the mode pins. The first fall after release then comes N-1 input edges later.
- R9: Stopping the input clock for any length of time, mid-period, does not change the number of input edges counted in that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_std | input | 1 | Mode select: 1 picks 64, 0 picks 65 (when `sel_wide`=0) |
| sel_wide | input | 1 | Mode select: 1 picks 72 regardless of `sel_std` |
| div_out | output | 1 | Divided output |
| div_out_n | output | 1 | Complement of `div_out` |

## Verification
The bench builds the block with its default parameters: a front base of 4, a five-bit secondary counter with terminal counts of 16 and 18, and the rise at count 32. With these values every modulus of interest fits within a period of 72 input edges. The bench therefore walks all sixteen ordered pairs of pin settings, measures the period before and after each pin change, and measures the rise position in each period. Reset in two different modes, a reverting pin glitch and a long clock stall in the middle of a period are also short enough to cover in full.

// File: rtl/tmd_pkg.sv
package tmd_pkg;

    typedef enum logic [1:0] {
        MODE_BASE    = 2'd0,
        MODE_SWALLOW = 2'd1,
        MODE_WIDE    = 2'd2
    } tmd_mode_e;

    function automatic tmd_mode_e pick_mode(input logic std_pin, input logic wide_pin);
        if (wide_pin)     return MODE_WIDE;
        else if (std_pin) return MODE_BASE;
        else              return MODE_SWALLOW;
    endfunction

endpackage

// File: rtl/tmd_front_stage.sv
module tmd_front_stage #(
    parameter int FRONT_BASE = 4,
    parameter int FW         = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          extend,
    output logic [FW-1:0] fc_q,
    output logic [FW-1:0] front_last,
    output logic          carry
);
    typedef struct packed {
        logic [FW-1:0] cnt;
    } front_st_t;

    front_st_t st_d, st_q;

    always_comb begin
        front_last = extend ? FW'(FRONT_BASE) : FW'(FRONT_BASE - 1);
        carry      = (st_q.cnt == front_last);
        st_d       = st_q;
        if (rst || carry) st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign fc_q = st_q.cnt;

    // R4: the fifth edge of a step only ever happens while extended
    assert_front_extend_R4: assert property (@(posedge clk) disable iff (rst)
        (fc_q == FW'(FRONT_BASE)) |-> extend);
    assert_front_range_R4: assert property (@(posedge clk) disable iff (rst)
        fc_q <= FW'(FRONT_BASE));
endmodule

// File: rtl/tmd_count_stage.sv
module tmd_count_stage #(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic [SW-1:0] term_m1,
    output logic [SW-1:0] sc_q,
    output logic          last
);
    typedef struct packed {
        logic [SW-1:0] cnt;
    } sec_st_t;

    sec_st_t st_d, st_q;

    always_comb begin
        last = (st_q.cnt == term_m1);
        st_d = st_q;
        if (rst)                 st_d.cnt = '0;
        else if (advance && last) st_d.cnt = '0;
        else if (advance)         st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign sc_q = st_q.cnt;

    // R4: secondary counter moves only on a front-stage step
    assert_sec_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(sc_q));
    assert_sec_range_R4: assert property (@(posedge clk) disable iff (rst)
        sc_q <= term_m1);
endmodule

// File: rtl/tmd_mode_reg.sv
module tmd_mode_reg
    import tmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wrap,
    input  logic      sel_std,
    input  logic      sel_wide,
    output tmd_mode_e mode_q
);
    typedef struct packed {
        tmd_mode_e mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || wrap) st_d.mode = pick_mode(sel_std, sel_wide);
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign mode_q = st_q.mode;

    // R6: the latched mode only changes on a period boundary
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(mode_q));
endmodule

// File: rtl/tmd_edge_shaper.sv
module tmd_edge_shaper #(
    parameter int FRONT_BASE = 4,
    parameter int FW         = 3,
    parameter int SW         = 5,
    parameter int RISE_COUNT = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] fc_q,
    input  logic [SW-1:0] sc_q,
    input  logic [FW-1:0] front_last,
    input  logic [SW-1:0] term_m1,
    output logic          out_q,
    output logic          outn_q
);
    // count k (1-based) sits at secondary step (k-1)/base, front index (k-1)%base;
    // RISE_COUNT-1 must not be a multiple of FRONT_BASE
    localparam int RISE_SEC   = (RISE_COUNT - 1) / FRONT_BASE;
    localparam int RISE_FRONT = (RISE_COUNT - 1) % FRONT_BASE;

    typedef struct packed {
        logic pos;
        logic neg;
    } wave_st_t;

    wave_st_t st_d, st_q;
    logic     pre_rise, pre_fall, at_final, at_rise;

    always_comb begin
        pre_rise = (sc_q == SW'(RISE_SEC)) && (fc_q == FW'(RISE_FRONT - 1));
        pre_fall = (sc_q == term_m1) && (fc_q == FW'(front_last - FW'(1)));
        at_final = (sc_q == term_m1) && (fc_q == front_last);
        at_rise  = (sc_q == SW'(RISE_SEC)) && (fc_q == FW'(RISE_FRONT));
        st_d = st_q;
        if (rst) begin
            st_d.pos = 1'b1;
            st_d.neg = 1'b0;
        end else if (pre_fall) begin
            st_d.pos = 1'b0;
            st_d.neg = 1'b1;
        end else if (pre_rise) begin
            st_d.pos = 1'b1;
            st_d.neg = 1'b0;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign out_q  = st_q.pos;
    assign outn_q = st_q.neg;

    // R5: edges land on the final count and on the rise count
    assert_fall_final_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(out_q) |-> at_final);
    assert_rise_pos_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> at_rise);
    // R7: both halves of the pair always disagree
    assert_pair_inverse_R7: assert property (@(posedge clk) disable iff (rst)
        outn_q == !out_q);
endmodule

// File: rtl/tri_modulus_divider.sv
module tri_modulus_divider
    import tmd_pkg::*;
#(
    parameter int FRONT_BASE    = 4,
    parameter int SW            = 5,
    parameter int SEC_TERM_STD  = 16,
    parameter int SEC_TERM_WIDE = 18,
    parameter int RISE_COUNT    = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_std,
    input  logic sel_wide,
    output logic div_out,
    output logic div_out_n
);
    localparam int FW = $clog2(FRONT_BASE + 1);

    tmd_mode_e      mode_q;
    logic [FW-1:0]  fc_q;
    logic [FW-1:0]  front_last;
    logic [SW-1:0]  sc_q;
    logic [SW-1:0]  term_m1;
    logic           carry, sec_last, extend, wrap;

    always_comb begin
        term_m1 = (mode_q == MODE_WIDE) ? SW'(SEC_TERM_WIDE - 1) : SW'(SEC_TERM_STD - 1);
        extend  = (mode_q == MODE_SWALLOW) && sec_last;
        wrap    = carry && sec_last;
    end

    tmd_mode_reg mode_i (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .sel_std  (sel_std),
        .sel_wide (sel_wide),
        .mode_q   (mode_q)
    );

    tmd_front_stage #(.FRONT_BASE(FRONT_BASE), .FW(FW)) front_i (
        .clk        (clk),
        .rst        (rst),
        .extend     (extend),
        .fc_q       (fc_q),
        .front_last (front_last),
        .carry      (carry)
    );

    tmd_count_stage #(.SW(SW)) sec_i (
        .clk     (clk),
        .rst     (rst),
        .advance (carry),
        .term_m1 (term_m1),
        .sc_q    (sc_q),
        .last    (sec_last)
    );

    tmd_edge_shaper #(
        .FRONT_BASE (FRONT_BASE),
        .FW         (FW),
        .SW         (SW),
        .RISE_COUNT (RISE_COUNT)
    ) shape_i (
        .clk        (clk),
        .rst        (rst),
        .fc_q       (fc_q),
        .sc_q       (sc_q),
        .front_last (front_last),
        .term_m1    (term_m1),
        .out_q      (div_out),
        .outn_q     (div_out_n)
    );

    // R8: one cycle after reset the output is high at count 1
    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (div_out && !div_out_n && fc_q == '0 && sc_q == '0));
endmodule

// File: tb/tri_modulus_divider_tb_top.sv
module tri_modulus_divider_tb_top;
    logic clk_raw = 1'b0;
    logic clk_en  = 1'b1;
    logic clk;
    logic rst     = 1'b1;
    logic sel_std = 1'b1;
    logic sel_wide = 1'b0;
    logic div_out, div_out_n;

    int tests  = 0;
    int fails  = 0;
    int pair_bad = 0;
    bit started = 1'b0;

    assign clk = clk_raw & clk_en;
    always #4 clk_raw = ~clk_raw;

    tri_modulus_divider dut_i (
        .clk       (clk),
        .rst       (rst),
        .sel_std   (sel_std),
        .sel_wide  (sel_wide),
        .div_out   (div_out),
        .div_out_n (div_out_n)
    );

    function automatic int modulus(input int p);
        if (p[1])      return 72;
        else if (p[0]) return 64;
        else           return 65;
    endfunction

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // R7 monitor: inverse relation at every sample
    always @(negedge clk_raw) if (started && div_out_n !== ~div_out) pair_bad++;

    // Count input edges up to the next fall. Optional pin changes at edge c1, c2;
    // optional clock stall at edge st. Checks the period and the rise position.
    task automatic measure(input int exp, input bit chk_rise, input string tag,
                           input int c1, input int p1, input int c2, input int p2,
                           input int st);
        int  n = 0;
        int  rise_at = -1;
        bit  prev = div_out;
        bit  done = 1'b0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            if (!prev && div_out) rise_at = n;
            if (prev && !div_out) done = 1'b1;
            prev = div_out;
            if (n == c1) begin sel_std = p1[0]; sel_wide = p1[1]; end
            if (n == c2) begin sel_std = p2[0]; sel_wide = p2[1]; end
            if (n == st) begin
                clk_en = 1'b0;
                repeat (60) @(negedge clk_raw);
                clk_en = 1'b1;
            end
        end
        check(n == exp, tag, n, exp);
        if (chk_rise) check(rise_at == 32, {tag, " R5 rise"}, rise_at, 32);
    endtask

    task automatic do_reset(input int p);
        @(negedge clk_raw);
        rst = 1'b1; sel_std = p[0]; sel_wide = p[1];
        repeat (3) @(negedge clk_raw);
        check(div_out == 1'b1 && div_out_n == 1'b0, "R8 reset state out", div_out, 1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk_raw);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cur;
        repeat (2) @(negedge clk_raw);
        started = 1'b1;
        do_reset(1);
        // R8: first fall N-1 edges after release
        measure(63, 1'b0, "R8 first period 64", -1, 0, -1, 0, -1);
        measure(64, 1'b1, "R1 period 64", -1, 0, -1, 0, -1);
        // R6: glitch that reverts before the boundary
        measure(64, 1'b1, "R6 glitch period", 10, 0, 40, 1, -1);
        measure(64, 1'b1, "R6 after glitch", -1, 0, -1, 0, -1);
        // R9: stall mid-period
        measure(64, 1'b1, "R9 stalled period", -1, 0, -1, 0, 20);
        measure(64, 1'b1, "R9 after stall", -1, 0, -1, 0, -1);
        // R1 R2 R3 R6: every ordered pair of pin settings
        cur = 64;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                measure(cur, 1'b1, $sformatf("R6 old mode before %0d", a), 5, a, -1, 0, -1);
                measure(modulus(a), 1'b1, $sformatf("R1_R2_R3 mode %0d", a), 20, b, -1, 0, -1);
                cur = modulus(b);
            end
        end
        // R2: explicit swallow mode
        measure(cur, 1'b1, "R2 settle", 5, 0, -1, 0, -1);
        measure(65, 1'b1, "R2 period 65", -1, 0, -1, 0, -1);
        // R3 R8: reset into wide mode with sel_std high
        do_reset(3);
        measure(71, 1'b0, "R8 first period 72", -1, 0, -1, 0, -1);
        measure(72, 1'b1, "R3 period 72 std high", -1, 0, -1, 0, -1);
        check(pair_bad == 0, "R7 complement mismatches", pair_bad, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule